// File: doc/BRIEF.md
# Accumulator Computer with Front-Panel Loader

This block is a small stored-program machine built around one 8-bit accumulator and a 64-word memory. Each instruction is fetched from memory at the program counter and latched into an instruction register. The program counter is then advanced, and the instruction executes in one or two further steps. Memory operands take the extra step. A control unit walks through these steps and raises one-cycle micro-operations: load or clear PC, step PC, load IR, clear, invert or shift the accumulator, add into it, write memory, and select the data address instead of the instruction address.

A front panel surrounds the machine. While the machine is halted and the panel is in manual mode, the address and data switches write memory one word at a time. Leaving manual mode and pulsing `start` clears PC and the accumulator and runs the program until a halt instruction executes or `stop` is raised. A panel read port shows the word at the switch address. A display output shows the address the machine is presenting to memory.

Top module: `acc_cpu`

## Requirements
- R1: After reset `halted` is 1, `pc` is 0 and `acc` is 0.
- R2: While halted with `man_mode`=1, a cycle with `sw_write`=1 stores `sw_data` at `sw_addr`. `panel_data` always shows the word at `sw_addr`.
- R3: `sw_write` has no effect while `man_mode`=0 or while the machine runs. `start` has no effect while `man_mode`=1.
- R4: `start`, seen while halted with `man_mode`=0, clears PC and the accumulator and begins fetching at address 0. A later `start` after a halt restarts from this cleared state.
- R5: An instruction is bits 7:6 opcode and bits 5:0 address. Opcode 00 selects a register operation by bits 5:3, with bits 2:0 ignored. 000 does nothing, 001 clears A, 010 inverts A, 011 shifts A right by one and 100 shifts A left by one. Both shifts fill with 0.
- R6: Sub-op 101 skips the next instruction when A bit 0 is 1. Sub-op 110 skips it when A bit 7 is 1.
- R7: Opcode 01 sets PC to the address field. Opcode 10 adds the memory word at the address field into A, keeping the low 8 bits. Opcode 11 writes A to the memory word at the address field.
- R8: Sub-op 111 halts the machine with PC holding the address after the halt word. A and memory keep their values.
- R9: From the `start` edge, `halted` rises after 1 cycle plus 3 cycles per register-op or jump instruction plus 4 cycles per add or store instruction. The final halt word counts as 3.
- R10: PC wraps from 63 to 0.
- R11: When `stop` is 1 at the point where the next fetch would begin, the machine halts without fetching. The halt comes within one instruction time.
- R12: `disp_addr` shows `sw_addr` while halted. While running it shows PC, except during the data steps of add and store, where it shows the address field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| man_mode | input | 1 | 1 = manual panel mode, 0 = automatic |
| sw_addr | input | 6 | Panel address switches |
| sw_data | input | 8 | Panel data switches |
| sw_write | input | 1 | Panel write strobe |
| start | input | 1 | Begin automatic execution |
| stop | input | 1 | Halt before the next fetch |
| disp_addr | output | 6 | Address display |
| panel_data | output | 8 | Memory word at `sw_addr` |
| pc | output | 6 | Program counter |
| acc | output | 8 | Accumulator |
| halted | output | 1 | Machine idle |

## Verification
The bench builds the block with its default 8-bit word, which gives a 6-bit address and 64 words. The whole address space is therefore small enough for the bench to preload every word and read back every word after each run. The PC wrap from 63 to 0 is reachable with a single jump. Random straight-line programs with forward jumps, skips, adds and stores are checked against a bench interpreter for the final accumulator, PC, memory image and cycle count. Directed programs cover add overflow, shift fill, both skip conditions, the wrap, the `stop` input, restart and ignored panel actions.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_INIT,
        PH_I1,
        PH_I2,
        PH_E1,
        PH_E2
    } phase_e;

    localparam logic [1:0] OPC_REG = 2'b00;
    localparam logic [1:0] OPC_JMP = 2'b01;
    localparam logic [1:0] OPC_ADD = 2'b10;
    localparam logic [1:0] OPC_MEM = 2'b11;

    localparam logic [2:0] SUB_NOP   = 3'd0;
    localparam logic [2:0] SUB_CLA   = 3'd1;
    localparam logic [2:0] SUB_CPL   = 3'd2;
    localparam logic [2:0] SUB_SHR   = 3'd3;
    localparam logic [2:0] SUB_SHL   = 3'd4;
    localparam logic [2:0] SUB_SKPLO = 3'd5;
    localparam logic [2:0] SUB_SKPHI = 3'd6;
    localparam logic [2:0] SUB_HALT  = 3'd7;

    typedef struct packed {
        logic clr_pc;
        logic ld_ir;
        logic inc_pc;
        logic ld_pc;
        logic clr_a;
        logic cpl_a;
        logic shr_a;
        logic shl_a;
        logic ld_a;
        logic wr_m;
        logic sel_data;
    } ucmd_t;

endpackage

// File: rtl/acc_cpu_mem.sv
module acc_cpu_mem #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr_cpu,
    output logic [DATA_W-1:0] rdata_cpu,
    input  logic [ADDR_W-1:0] raddr_pnl,
    output logic [DATA_W-1:0] rdata_pnl
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            words_q[waddr] <= wdata;
        end
    end

    assign rdata_cpu = words_q[raddr_cpu];
    assign rdata_pnl = words_q[raddr_pnl];
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] acc_q,
    input  logic [DATA_W-1:0] operand,
    input  logic              clr_a,
    input  logic              cpl_a,
    input  logic              shr_a,
    input  logic              shl_a,
    input  logic              ld_a,
    output logic [DATA_W-1:0] acc_d
);
    always_comb begin
        acc_d = acc_q;
        if (clr_a) begin
            acc_d = '0;
        end else if (cpl_a) begin
            acc_d = ~acc_q;
        end else if (shr_a) begin
            acc_d = {1'b0, acc_q[DATA_W-1:1]};
        end else if (shl_a) begin
            acc_d = {acc_q[DATA_W-2:0], 1'b0};
        end else if (ld_a) begin
            acc_d = acc_q + operand;
        end
    end
endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [4:0] op_sub,
    input  logic       acc_lsb,
    input  logic       acc_msb,
    input  logic       start,
    input  logic       stop,
    input  logic       man_mode,
    output ucmd_t      ucmd,
    output logic       halted
);
    typedef struct packed {
        phase_e ph;
    } ctrl_t;

    ctrl_t st_d, st_q;

    logic [1:0] major;
    logic [2:0] sub;

    assign major = op_sub[4:3];
    assign sub   = op_sub[2:0];

    always_comb begin
        st_d = st_q;
        ucmd = '0;
        case (st_q.ph)
            PH_IDLE: begin
                if (start && !man_mode) st_d.ph = PH_INIT;
            end
            PH_INIT: begin
                ucmd.clr_pc = 1'b1;
                ucmd.clr_a  = 1'b1;
                st_d.ph     = PH_I1;
            end
            PH_I1: begin
                if (stop) begin
                    st_d.ph = PH_IDLE;
                end else begin
                    ucmd.ld_ir = 1'b1;
                    st_d.ph    = PH_I2;
                end
            end
            PH_I2: begin
                ucmd.inc_pc = 1'b1;
                st_d.ph     = PH_E1;
            end
            PH_E1: begin
                st_d.ph = PH_I1;
                case (major)
                    OPC_REG: begin
                        case (sub)
                            SUB_CLA:   ucmd.clr_a  = 1'b1;
                            SUB_CPL:   ucmd.cpl_a  = 1'b1;
                            SUB_SHR:   ucmd.shr_a  = 1'b1;
                            SUB_SHL:   ucmd.shl_a  = 1'b1;
                            SUB_SKPLO: ucmd.inc_pc = acc_lsb;
                            SUB_SKPHI: ucmd.inc_pc = acc_msb;
                            SUB_HALT:  st_d.ph     = PH_IDLE;
                            default:   ;
                        endcase
                    end
                    OPC_JMP: ucmd.ld_pc = 1'b1;
                    default: begin
                        ucmd.sel_data = 1'b1;
                        st_d.ph       = PH_E2;
                    end
                endcase
            end
            PH_E2: begin
                ucmd.sel_data = 1'b1;
                if (major == OPC_ADD) ucmd.ld_a = 1'b1;
                else                  ucmd.wr_m = 1'b1;
                st_d.ph = PH_I1;
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ph: PH_IDLE};
        else        st_q <= st_d;
    end

    assign halted = (st_q.ph == PH_IDLE);

    a_r8_halt_word_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_E1 && major == OPC_REG && sub == SUB_HALT) |=> halted);

    a_r3_start_needs_auto: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && man_mode) |=> halted);

    a_r11_stop_before_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_I1 && stop) |=> halted);

    a_r9_data_step_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_E1 && major[1]) |=> (st_q.ph == PH_E2));

    a_r7_one_data_action: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ucmd.ld_a, ucmd.wr_m, ucmd.ld_pc, ucmd.ld_ir}) <= 1);
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                man_mode,
    input  logic [DATA_W-3:0]   sw_addr,
    input  logic [DATA_W-1:0]   sw_data,
    input  logic                sw_write,
    input  logic                start,
    input  logic                stop,
    output logic [DATA_W-3:0]   disp_addr,
    output logic [DATA_W-1:0]   panel_data,
    output logic [DATA_W-3:0]   pc,
    output logic [DATA_W-1:0]   acc,
    output logic                halted
);
    localparam int ADDR_W = DATA_W - 2;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] ir;
    } regs_t;

    regs_t             r_d, r_q;
    ucmd_t             ucmd;
    logic              halted_w;
    logic [ADDR_W-1:0] ir_addr;
    logic [ADDR_W-1:0] cpu_addr;
    logic [DATA_W-1:0] cpu_rdata;
    logic [DATA_W-1:0] acc_next;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [DATA_W-1:0] mem_wdata;

    assign ir_addr  = r_q.ir[ADDR_W-1:0];
    assign cpu_addr = ucmd.sel_data ? ir_addr : r_q.pc;

    acc_cpu_ctrl i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_sub   (r_q.ir[DATA_W-1 -: 5]),
        .acc_lsb  (r_q.acc[0]),
        .acc_msb  (r_q.acc[DATA_W-1]),
        .start    (start),
        .stop     (stop),
        .man_mode (man_mode),
        .ucmd     (ucmd),
        .halted   (halted_w)
    );

    acc_cpu_alu #(.DATA_W(DATA_W)) i_alu (
        .acc_q   (r_q.acc),
        .operand (cpu_rdata),
        .clr_a   (ucmd.clr_a),
        .cpl_a   (ucmd.cpl_a),
        .shr_a   (ucmd.shr_a),
        .shl_a   (ucmd.shl_a),
        .ld_a    (ucmd.ld_a),
        .acc_d   (acc_next)
    );

    always_comb begin
        mem_we    = ucmd.wr_m || (halted_w && man_mode && sw_write);
        mem_waddr = halted_w ? sw_addr : ir_addr;
        mem_wdata = halted_w ? sw_data : r_q.acc;
    end

    acc_cpu_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_mem (
        .clk       (clk),
        .we        (mem_we),
        .waddr     (mem_waddr),
        .wdata     (mem_wdata),
        .raddr_cpu (cpu_addr),
        .rdata_cpu (cpu_rdata),
        .raddr_pnl (sw_addr),
        .rdata_pnl (panel_data)
    );

    always_comb begin
        r_d     = r_q;
        r_d.acc = acc_next;
        if (ucmd.clr_pc)      r_d.pc = '0;
        else if (ucmd.ld_pc)  r_d.pc = ir_addr;
        else if (ucmd.inc_pc) r_d.pc = r_q.pc + 1'b1;
        if (ucmd.ld_ir) r_d.ir = cpu_rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign pc        = r_q.pc;
    assign acc       = r_q.acc;
    assign halted    = halted_w;
    assign disp_addr = halted_w ? sw_addr : cpu_addr;

    a_r10_pc_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (ucmd.inc_pc && !ucmd.ld_pc && !ucmd.clr_pc)
        |=> (r_q.pc == ADDR_W'($past(r_q.pc) + 1'b1)));

    a_r4_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ucmd.clr_pc |=> (r_q.pc == '0 && r_q.acc == '0));

    a_r7_add_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        ucmd.ld_a |=> (r_q.acc == DATA_W'($past(r_q.acc) + $past(cpu_rdata))));

    a_r5_fetch_latches: assert property (@(posedge clk) disable iff (!rst_n)
        ucmd.ld_ir |=> (r_q.ir == $past(cpu_rdata)));

    a_r3_panel_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (ucmd.wr_m || halted_w));

    a_r8_halt_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_w && $past(halted_w)) |-> $stable(r_q.acc));
endmodule

// File: tb/test_acc_cpu.sv
`timescale 1ns/1ps
module test_acc_cpu;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       man_mode = 1'b1;
    logic [5:0] sw_addr = '0;
    logic [7:0] sw_data = '0;
    logic       sw_write = 1'b0;
    logic       start = 1'b0;
    logic       stop = 1'b0;
    logic [5:0] disp_addr;
    logic [7:0] panel_data;
    logic [5:0] pc;
    logic [7:0] acc;
    logic       halted;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] prog [64];
    logic [7:0] mm   [64];
    logic [7:0] m_acc;
    logic [5:0] m_pc;
    int         m_cyc;
    int         run_cyc;
    logic [5:0] disp_tr [8];

    always #2 clk = ~clk;

    acc_cpu i_acc_cpu (
        .clk(clk), .rst_n(rst_n), .man_mode(man_mode), .sw_addr(sw_addr),
        .sw_data(sw_data), .sw_write(sw_write), .start(start), .stop(stop),
        .disp_addr(disp_addr), .panel_data(panel_data), .pc(pc), .acc(acc),
        .halted(halted)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic panel_write(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        sw_addr = a; sw_data = d; sw_write = 1'b1;
        @(negedge clk);
        sw_write = 1'b0;
    endtask

    task automatic panel_read(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        sw_addr = a;
        #1 d = panel_data;
    endtask

    task automatic load_prog();
        @(negedge clk);
        man_mode = 1'b1;
        for (int i = 0; i < 64; i++) panel_write(6'(i), prog[i]);
    endtask

    // Bench interpreter written from R4..R10
    task automatic model_run();
        logic [7:0] ins;
        logic [5:0] p;
        logic [7:0] a;
        for (int i = 0; i < 64; i++) mm[i] = prog[i];
        p = 0; a = 0; m_cyc = 1;
        for (int s = 0; s < 4000; s++) begin
            ins = mm[p];
            p = p + 6'd1;
            m_cyc += 3;
            if (ins[7:6] == 2'b00) begin
                if (ins[5:3] == 3'd7) break;
                case (ins[5:3])
                    3'd1: a = 8'h00;
                    3'd2: a = ~a;
                    3'd3: a = a >> 1;
                    3'd4: a = a << 1;
                    3'd5: if (a[0]) p = p + 6'd1;
                    3'd6: if (a[7]) p = p + 6'd1;
                    default: ;
                endcase
            end else if (ins[7:6] == 2'b01) begin
                p = ins[5:0];
            end else if (ins[7:6] == 2'b10) begin
                a = a + mm[ins[5:0]];
                m_cyc += 1;
            end else begin
                mm[ins[5:0]] = a;
                m_cyc += 1;
            end
        end
        m_acc = a; m_pc = p;
    endtask

    task automatic run_prog();
        @(negedge clk);
        man_mode = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        run_cyc = 0;
        for (int k = 0; k < 5000; k++) begin
            @(posedge clk);
            run_cyc++;
            @(negedge clk);
            if (run_cyc < 8) disp_tr[run_cyc] = disp_addr;
            if (halted) break;
        end
    endtask

    task automatic compare_model(input string tag);
        logic [7:0] d;
        model_run();
        check(halted === 1'b1, "R8", {tag, " halted"}, int'(halted), 1);
        check(acc === m_acc, "R7", {tag, " acc"}, acc, m_acc);
        check(pc === m_pc, "R8", {tag, " pc"}, pc, m_pc);
        check(run_cyc == m_cyc, "R9", {tag, " cycles"}, run_cyc, m_cyc);
        for (int i = 0; i < 64; i++) begin
            panel_read(6'(i), d);
            if (d !== mm[i]) check(1'b0, "R7", {tag, " memory word"}, d, mm[i]);
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(halted === 1'b1, "R1", "halted", int'(halted), 1);
        check(pc === 6'd0, "R1", "pc", pc, 0);
        check(acc === 8'd0, "R1", "acc", acc, 0);
        rst_n = 1'b1;

        // R2 panel write and read back, R12 display while halted
        panel_write(6'd33, 8'hC3);
        panel_read(6'd33, d);
        check(d === 8'hC3, "R2", "panel readback", d, 8'hC3);
        check(disp_addr === 6'd33, "R12", "display halted", disp_addr, 33);

        // Directed program: add wrap, shifts, invert, store, skips
        for (int i = 0; i < 64; i++) prog[i] = 8'h00;
        prog[0] = 8'hA8; prog[1] = 8'hA9; prog[2] = 8'h20; prog[3] = 8'h10;
        prog[4] = 8'h18; prog[5] = 8'hEA; prog[6] = 8'h28; prog[7] = 8'h08;
        prog[8] = 8'h30; prog[9] = 8'h3F;
        prog[40] = 8'hF0; prog[41] = 8'h20;
        load_prog();
        run_prog();
        check(acc === 8'h6F, "R5", "directed acc", acc, 8'h6F);
        check(pc === 6'd10, "R8", "directed pc", pc, 10);
        check(run_cyc == 31, "R9", "directed cycles", run_cyc, 31);
        check(disp_tr[1] === 6'd0, "R12", "display at fetch", disp_tr[1], 0);
        check(disp_tr[3] === 6'd40, "R12", "display at data step", disp_tr[3], 40);
        panel_read(6'd42, d);
        check(d === 8'h6F, "R7", "store result", d, 8'h6F);
        compare_model("directed");

        // R4 restart from cleared state gives the same result
        run_prog();
        check(acc === 8'h6F, "R4", "restart acc", acc, 8'h6F);
        check(run_cyc == 31, "R4", "restart cycles", run_cyc, 31);

        // R10 PC wrap and R6 skip on high bit
        for (int i = 0; i < 64; i++) prog[i] = 8'h00;
        prog[0] = 8'h30; prog[1] = 8'h7E; prog[2] = 8'h38;
        prog[62] = 8'h10; prog[63] = 8'h00;
        load_prog();
        run_prog();
        check(acc === 8'hFF, "R10", "wrap acc", acc, 8'hFF);
        check(pc === 6'd3, "R10", "wrap pc", pc, 3);
        check(run_cyc == 19, "R6", "wrap cycles", run_cyc, 19);

        // R3 panel write ignored in auto mode, start ignored in manual mode
        @(negedge clk);
        man_mode = 1'b0;
        sw_addr = 6'd62; sw_data = 8'h5A; sw_write = 1'b1;
        @(negedge clk);
        sw_write = 1'b0;
        panel_read(6'd62, d);
        check(d === 8'h10, "R3", "auto mode write ignored", d, 8'h10);
        @(negedge clk);
        man_mode = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        check(halted === 1'b1, "R3", "start ignored in manual", int'(halted), 1);
        check(pc === 6'd3, "R3", "pc kept in manual", pc, 3);

        // R11 stop input on an endless loop, R3 write ignored while running
        for (int i = 0; i < 64; i++) prog[i] = 8'h00;
        prog[0] = 8'h40;
        load_prog();
        @(negedge clk);
        man_mode = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        check(halted === 1'b0, "R11", "loop running", int'(halted), 0);
        man_mode = 1'b1;
        sw_addr = 6'd1; sw_data = 8'hEE; sw_write = 1'b1;
        @(negedge clk);
        sw_write = 1'b0;
        stop = 1'b1;
        repeat (6) @(negedge clk);
        stop = 1'b0;
        check(halted === 1'b1, "R11", "stop halts", int'(halted), 1);
        panel_read(6'd1, d);
        check(d === 8'h00, "R3", "running write ignored", d, 0);

        // Random programs against the interpreter
        for (int t = 0; t < 20; t++) begin
            int len;
            len = 8 + int'($urandom % 23);
            for (int i = 0; i < 64; i++) prog[i] = 8'h00;
            for (int i = 40; i < 64; i++) prog[i] = 8'($urandom);
            for (int i = 0; i < len; i++) begin
                int r;
                int tg;
                r = int'($urandom % 5);
                case (r)
                    0: prog[i] = {2'b00, 3'($urandom % 7), 3'($urandom)};
                    1, 4: prog[i] = {2'b10, 6'(40 + $urandom % 24)};
                    2: prog[i] = {2'b11, 6'(40 + $urandom % 24)};
                    default: begin
                        tg = i + 1 + int'($urandom % 3);
                        prog[i] = (tg < len) ? {2'b01, 6'(tg)} : 8'h00;
                    end
                endcase
            end
            prog[len] = 8'h38; prog[len + 1] = 8'h3A;
            load_prog();
            run_prog();
            compare_model("random");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule